// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two component predictors side by side and lets a third table pick between them. The global component keys a table of 2-bit counters with the recent outcomes of all branches. The local component has two levels. It first looks up a short outcome history kept for the branch's own address slot, and then uses that history to select a 3-bit counter. The chooser is a table of 2-bit counters, keyed by the global history, that learns which component has been right more often in that context.

A fetch stage presents a PC on the predict stream and receives the guess in the same cycle, together with the two table indices that the guess used. When the branch resolves, the pipeline sends the PC, the real outcome and those saved indices to the update stream. The update trains both component counters and the chooser, and it shifts the outcome into the global history and into the branch's local history. Both streams are valid/ready. Both ready outputs are held high, so the block never applies back-pressure: the guess is valid in any cycle where the predict valid is high, and an update is consumed in any cycle where the update valid is high. Lookups see the state as it stood before the update that completes at the same clock edge.

Top module: `tourney_bp`

## Requirements
- R1: After a synchronous reset, the global history and every local history are zero. Every global and local counter is weakly not-taken (2-bit value 1, 3-bit value 3) and every chooser entry holds 1 (weakly local), so the first guess is not-taken with both indices zero.
- R2: `pred_gidx` shows the global history. Each accepted update shifts it left by one with the outcome entering at bit 0 (1 = taken), so bit i holds the outcome of the i-th prior update.
- R3: `pred_lidx` is the local history stored at slot `pred_pc[11:2]`. Each accepted update shifts the outcome into bit 0 of the slot at `upd_pc[11:2]`.
- R4: Local counters are 3 bits wide, are indexed by `upd_lidx` on update and `pred_lidx` on lookup, vote taken at values 4..7, and saturate at 0 and 7.
- R5: Global counters are 2 bits wide, are indexed by `upd_gidx` on update and by the global history on lookup, vote taken at values 2..3, and saturate at 0 and 3.
- R6: `pred_taken` is `pred_valid` AND the vote of the selected component. The global component is selected when the chooser entry at the current global history is 2 or 3, and the local component when it is 0 or 1.
- R7: On update, the chooser entry at `upd_gidx` moves one step, saturating, toward the correct component, and only when the global counter at `upd_gidx` and the local counter at `upd_lidx` voted differently.
- R8: A cycle with `upd_valid` low changes no history and no counter, whatever the other update inputs carry.
- R9: `pred_ready` and `upd_ready` are high in every cycle after reset.
- R10: Local history slots carry no tag, so PCs that agree in bits [11:2] share one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_valid | input | 1 | Lookup request valid |
| pred_ready | output | 1 | Lookup accepted (always high) |
| pred_pc | input | 32 | Fetch PC to look up |
| pred_taken | output | 1 | Guess: 1 = taken |
| pred_gidx | output | 12 | Global history used as the global and chooser index |
| pred_lidx | output | 10 | Local history used as the local counter index |
| upd_valid | input | 1 | Resolved branch valid |
| upd_ready | output | 1 | Update accepted (always high) |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome: 1 = taken |
| upd_gidx | input | 12 | Global index saved from the lookup |
| upd_lidx | input | 10 | Local index saved from the lookup |

## Verification
A corrupted history appears at the index outputs in the cycle that follows the faulty update, because both index outputs expose history state directly. A corrupted counter or chooser entry stays hidden until a later lookup lands on that entry with the matching selection. The bench therefore follows every table entry in its own model and steers directed sequences so that saturation limits and chooser flips show up in `pred_taken` within a few cycles. Random traffic is replayed through the same model to cover aliasing and stale indices.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic {PICK_LOCAL = 1'b0, PICK_GLOBAL = 1'b1} pick_e;

  // the upper half of a chooser counter selects the global component
  function automatic pick_e pick_from_msb(input logic msb);
    return msb ? PICK_GLOBAL : PICK_LOCAL;
  endfunction
endpackage

// File: rtl/sat_ctr_table.sv
module sat_ctr_table #(
  parameter int IDX_W   = 12,
  parameter int CTR_W   = 2,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_val,
  input  logic [IDX_W-1:0] chk_idx,
  output logic [CTR_W-1:0] chk_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_RST = CTR_W'(RST_VAL);

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur;

  assign rd_val  = mem[rd_idx];
  assign chk_val = mem[chk_idx];
  assign cur     = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RST;
    end else if (wr_en) begin
      if (wr_up && cur != CTR_MAX) mem[wr_idx] <= cur + 1'b1;
      else if (!wr_up && cur != '0) mem[wr_idx] <= cur - 1'b1;
    end
  end
endmodule

// File: rtl/local_hist_table.sv
module local_hist_table #(
  parameter int IDX_W = 10,
  parameter int H_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [H_W-1:0]   rd_hist,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [H_W-1:0] mem [DEPTH];
  logic [H_W-1:0] cur;

  assign rd_hist = mem[rd_idx];
  assign cur     = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {cur[H_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LO     = 2,
  parameter int GH_W      = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10,
  parameter int G_CTR_W   = 2,
  parameter int L_CTR_W   = 3,
  parameter int CH_CTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_valid,
  output logic            pred_ready,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic [GH_W-1:0] pred_gidx,
  output logic [LH_W-1:0] pred_lidx,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [GH_W-1:0] upd_gidx,
  input  logic [LH_W-1:0] upd_lidx
);
  // weakly not-taken, and weakly local for the chooser
  localparam int G_RST  = (1 << (G_CTR_W - 1)) - 1;
  localparam int L_RST  = (1 << (L_CTR_W - 1)) - 1;
  localparam int CH_RST = (1 << (CH_CTR_W - 1)) - 1;
  localparam int PC_HI  = PC_LO + LHT_IDX_W;

  logic [GH_W-1:0]     ghist_q;
  logic [G_CTR_W-1:0]  g_rd, g_chk;
  logic [L_CTR_W-1:0]  l_rd, l_chk;
  logic [CH_CTR_W-1:0] ch_rd, ch_chk_unused;
  logic                g_vote_upd, l_vote_upd, disagree, global_right;
  pick_e               pick;
  logic                unused_pc_bits;

  assign unused_pc_bits = ^{pred_pc[PC_W-1:PC_HI], pred_pc[PC_LO-1:0],
                            upd_pc[PC_W-1:PC_HI], upd_pc[PC_LO-1:0]};

  assign pred_ready = 1'b1;
  assign upd_ready  = 1'b1;

  // global outcome history, non-speculative
  always_ff @(posedge clk) begin
    if (rst) ghist_q <= '0;
    else if (upd_valid) ghist_q <= {ghist_q[GH_W-2:0], upd_taken};
  end

  local_hist_table #(.IDX_W(LHT_IDX_W), .H_W(LH_W)) u_lht (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (pred_pc[PC_LO +: LHT_IDX_W]),
    .rd_hist (pred_lidx),
    .wr_en   (upd_valid),
    .wr_idx  (upd_pc[PC_LO +: LHT_IDX_W]),
    .wr_bit  (upd_taken)
  );

  sat_ctr_table #(.IDX_W(GH_W), .CTR_W(G_CTR_W), .RST_VAL(G_RST)) u_gtab (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (ghist_q),
    .rd_val  (g_rd),
    .chk_idx (upd_gidx),
    .chk_val (g_chk),
    .wr_en   (upd_valid),
    .wr_idx  (upd_gidx),
    .wr_up   (upd_taken)
  );

  sat_ctr_table #(.IDX_W(LH_W), .CTR_W(L_CTR_W), .RST_VAL(L_RST)) u_ltab (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (pred_lidx),
    .rd_val  (l_rd),
    .chk_idx (upd_lidx),
    .chk_val (l_chk),
    .wr_en   (upd_valid),
    .wr_idx  (upd_lidx),
    .wr_up   (upd_taken)
  );

  // component votes at update time decide whether the chooser learns
  assign g_vote_upd   = g_chk[G_CTR_W-1];
  assign l_vote_upd   = l_chk[L_CTR_W-1];
  assign disagree     = g_vote_upd ^ l_vote_upd;
  assign global_right = (g_vote_upd == upd_taken);

  sat_ctr_table #(.IDX_W(GH_W), .CTR_W(CH_CTR_W), .RST_VAL(CH_RST)) u_chooser (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (ghist_q),
    .rd_val  (ch_rd),
    .chk_idx (upd_gidx),
    .chk_val (ch_chk_unused),
    .wr_en   (upd_valid && disagree),
    .wr_idx  (upd_gidx),
    .wr_up   (global_right)
  );

  assign pick       = pick_from_msb(ch_rd[CH_CTR_W-1]);
  assign pred_gidx  = ghist_q;
  assign pred_taken = pred_valid &
                      ((pick == PICK_GLOBAL) ? g_rd[G_CTR_W-1] : l_rd[L_CTR_W-1]);
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int PC_W      = 32,
  parameter int PC_LO     = 2,
  parameter int GH_W      = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            pred_ready,
  input logic            upd_ready,
  input logic [PC_W-1:0] pred_pc,
  input logic [GH_W-1:0] pred_gidx,
  input logic [LH_W-1:0] pred_lidx,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken
);
  logic [LHT_IDX_W-1:0] p_slot, u_slot;
  assign p_slot = pred_pc[PC_LO +: LHT_IDX_W];
  assign u_slot = upd_pc[PC_LO +: LHT_IDX_W];

  // R1
  reset_hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pred_gidx == '0 && pred_lidx == '0));

  // R2
  ghist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> pred_gidx == {$past(pred_gidx[GH_W-2:0]), $past(upd_taken)});

  // R3
  lhist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && p_slot == u_slot) |=>
      (p_slot != $past(p_slot)) ||
      (pred_lidx == {$past(pred_lidx[LH_W-2:0]), $past(upd_taken)}));

  // R8
  idle_ghist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(pred_gidx));

  // R8
  idle_lhist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> (p_slot != $past(p_slot)) || $stable(pred_lidx));

  // R9
  never_stall_chk: assert property (@(posedge clk) disable iff (rst)
    pred_ready && upd_ready);
endmodule

bind tourney_bp tourney_bp_chk #(
  .PC_W(PC_W), .PC_LO(PC_LO), .GH_W(GH_W), .LHT_IDX_W(LHT_IDX_W), .LH_W(LH_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pred_ready (pred_ready),
  .upd_ready  (upd_ready),
  .pred_pc    (pred_pc),
  .pred_gidx  (pred_gidx),
  .pred_lidx  (pred_lidx),
  .upd_valid  (upd_valid),
  .upd_pc     (upd_pc),
  .upd_taken  (upd_taken)
);

// File: tb/tourney_bp_bench.sv
module tourney_bp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic        pred_valid, pred_ready, pred_taken;
  logic [31:0] pred_pc;
  logic [11:0] pred_gidx;
  logic [9:0]  pred_lidx;
  logic        upd_valid, upd_ready, upd_taken;
  logic [31:0] upd_pc;
  logic [11:0] upd_gidx;
  logic [9:0]  upd_lidx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of every table
  logic [1:0]  m_ch [4096];
  logic [1:0]  m_g  [4096];
  logic [2:0]  m_l  [1024];
  logic [9:0]  m_lh [1024];
  logic [11:0] m_gh;

  tourney_bp u_tourney_bp (
    .clk(clk), .rst(rst),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_gidx(pred_gidx), .pred_lidx(pred_lidx),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_gidx(upd_gidx), .upd_lidx(upd_lidx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 4096; i++) begin m_ch[i] = 2'd1; m_g[i] = 2'd1; end
    for (int i = 0; i < 1024; i++) begin m_l[i] = 3'd3; m_lh[i] = '0; end
    m_gh = '0;
  endfunction

  function automatic logic model_pick(input logic [31:0] pc);
    logic [9:0] li;
    li = m_lh[pc[11:2]];
    return (m_ch[m_gh] >= 2'd2) ? (m_g[m_gh] >= 2'd2) : (m_l[li] >= 3'd4);
  endfunction

  function automatic void model_update(input logic [31:0] pc, input logic t,
                                       input logic [11:0] gi, input logic [9:0] li);
    logic gp, lp;
    gp = m_g[gi] >= 2'd2;
    lp = m_l[li] >= 3'd4;
    if (gp != lp) begin
      if (gp == t) begin if (m_ch[gi] != 2'd3) m_ch[gi] = m_ch[gi] + 2'd1; end
      else begin if (m_ch[gi] != 2'd0) m_ch[gi] = m_ch[gi] - 2'd1; end
    end
    if (t) begin
      if (m_g[gi] != 2'd3) m_g[gi] = m_g[gi] + 2'd1;
      if (m_l[li] != 3'd7) m_l[li] = m_l[li] + 3'd1;
    end else begin
      if (m_g[gi] != 2'd0) m_g[gi] = m_g[gi] - 2'd1;
      if (m_l[li] != 3'd0) m_l[li] = m_l[li] - 3'd1;
    end
    m_lh[pc[11:2]] = {m_lh[pc[11:2]][8:0], t};
    m_gh = {m_gh[10:0], t};
  endfunction

  // one cycle: drive at the falling edge, check outputs, model the rising edge
  task automatic cyc(input logic pv, input logic [31:0] pc, input logic uv,
                     input logic [31:0] upc, input logic ut, input logic [11:0] ugi,
                     input logic [9:0] uli, input string tag);
    @(negedge clk);
    pred_valid = pv; pred_pc = pc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_gidx = ugi; upd_lidx = uli;
    #1;
    chk({tag, " R6 taken"}, {31'd0, pred_taken}, {31'd0, pv & model_pick(pc)});
    chk({tag, " R2 gidx"}, {20'd0, pred_gidx}, {20'd0, m_gh});
    chk({tag, " R3 lidx"}, {22'd0, pred_lidx}, {22'd0, m_lh[pc[11:2]]});
    @(posedge clk);
    if (uv) model_update(upc, ut, ugi, uli);
  endtask

  task automatic run_branch(input logic [31:0] pc, input logic t, input string tag);
    cyc(1'b1, pc, 1'b1, pc, t, m_gh, m_lh[pc[11:2]], tag);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pcs [8];
    int trip [8];
    void'($urandom(32'd4711));
    rst = 1'b1; pred_valid = 0; pred_pc = 0; upd_valid = 0; upd_pc = 0;
    upd_taken = 0; upd_gidx = 0; upd_lidx = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state, R9 ready
    cyc(1'b1, 32'h0, 1'b0, 32'h0, 1'b0, 12'd0, 10'd0, "R1 reset");
    chk("R1 first guess not-taken", {31'd0, pred_taken}, 32'd0);
    chk("R9 pred_ready", {31'd0, pred_ready}, 32'd1);
    chk("R9 upd_ready", {31'd0, upd_ready}, 32'd1);

    // R4 local counter climbs past 4, saturates at 7, then falls
    cyc(1'b1, 32'h0, 1'b1, 32'h4, 1'b1, 12'd0, 10'd0, "R4 step");
    #1 chk("R4 local reaches taken at 4", {31'd0, pred_taken}, 32'd1);
    repeat (4) cyc(1'b1, 32'h0, 1'b1, 32'h4, 1'b1, 12'd0, 10'd0, "R4 climb");
    repeat (3) cyc(1'b1, 32'h0, 1'b1, 32'h4, 1'b0, 12'd0, 10'd0, "R4 after sat");
    cyc(1'b1, 32'h0, 1'b0, 32'h4, 1'b0, 12'd0, 10'd0, "R4 sat held");
    chk("R4 saturated at 7 then three decrements still taken", {31'd0, pred_taken}, 32'd1);
    repeat (8) cyc(1'b1, 32'h0, 1'b1, 32'h4, 1'b0, 12'd0, 10'd0, "R4 floor");
    cyc(1'b1, 32'h0, 1'b1, 32'h4, 1'b1, 12'd0, 10'd0, "R4 low sat");

    // R5 global counter saturation and R7 chooser flip toward global
    repeat (5) cyc(1'b0, 32'h0, 1'b1, 32'h8, 1'b1, 12'd3, 10'd9, "R5 climb");
    cyc(1'b0, 32'h0, 1'b1, 32'h8, 1'b1, 12'd3, 10'd20, "R7 disagree");
    repeat (10) cyc(1'b1, 32'h40, 1'b1, 32'hC, 1'b0, 12'd100, 10'd200, "R7 steer");
    repeat (2) cyc(1'b1, 32'h40, 1'b1, 32'hC, 1'b1, 12'd101, 10'd201, "R7 steer");
    cyc(1'b1, 32'h40, 1'b0, 32'h0, 1'b0, 12'd0, 10'd0, "R7 global picked");
    chk("R7 chooser now selects saturated global", {31'd0, pred_taken}, 32'd1);
    chk("R5 global history value 3", {20'd0, pred_gidx}, 32'd3);

    // R8 idle updates with junk fields change nothing
    for (int i = 0; i < 20; i++)
      cyc(1'b1, 32'h40, 1'b0, $urandom, 1'($urandom), 12'($urandom), 10'($urandom), "R8 idle");
    chk("R8 history unchanged", {20'd0, pred_gidx}, 32'd3);

    // R10 aliasing: upper bits and low byte bits ignored
    repeat (3) run_branch(32'h0000_1230, 1'b1, "R10 train");
    cyc(1'b1, 32'h8000_1233, 1'b0, 32'h0, 1'b0, 12'd0, 10'd0, "R10 alias");
    chk("R10 shared local slot", {22'd0, pred_lidx}, {22'd0, 10'b111});

    // random traffic with loop-like branches, stale indices and idles
    for (int k = 0; k < 8; k++) begin pcs[k] = 32'h2000 + 32'(k * 4) + (32'(k) << 20); trip[k] = 0; end
    for (int n = 0; n < 4000; n++) begin
      int k, r;
      logic t;
      k = $urandom_range(7);
      r = $urandom_range(99);
      if (k < 5) begin
        trip[k]++;
        t = (trip[k] % (k + 2)) != 0;
      end else t = 1'($urandom);
      if (r < 10)
        cyc(1'($urandom), pcs[k], 1'b0, $urandom, t, 12'($urandom), 10'($urandom), "R8 rand idle");
      else if (r < 20)
        cyc(1'b1, pcs[$urandom_range(7)], 1'b1, pcs[k], t, 12'($urandom), 10'($urandom), "R4 R5 R7 stale");
      else
        run_branch(pcs[k], t, "R4 R5 R7 R10 rand");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule